// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a software heartbeat. Firmware services it by toggling a kick input. Every change of level counts as service, whether the input rises or falls. If no change arrives within a programmed number of prescaled clock ticks, the block pulls its active-low watchdog output down. It also raises a one-cycle expiry strobe. The strobe can feed the watchdog request of a reset stretcher. The level output can be looped back to a manual-reset input, so that a missed deadline becomes a system reset.

While the supervisor holds the system in reset, the timer is held at zero and does not count. Counting starts on the first cycle after reset is released. The watchdog output also goes low at once whenever the supply-undervoltage flag is set. It comes back high in the same cycle the flag clears, unless a time-out is still pending. A pending time-out is cleared only by a kick. The function cannot be switched off: a kick input held at either level still times out.

The kick input passes through a synchronizer. The edge detector samples every clock, so any kick level lasting at least one clock period is seen.

Top module: `kick_wdt`

## Requirements
- R1: After rst_ni is released, wdog_no is 1 and expire_o is 0 while no time-out and no undervoltage are present.
- R2: With no kick edge and sys_rst_i low, wdog_no goes to 0 exactly PRESCALE*TIMEOUT_TICKS clock edges after the last edge that cleared the timer. expire_o is 1 for that same cycle.
- R3: A rising and a falling transition of kick_i each clear the timer and any pending time-out. The clearing edge is the (SYNC_STAGES+1)-th rising clock edge after the transition.
- R4: While sys_rst_i is 1, the timer is held cleared and cannot expire. Counting resumes from zero on the first edge with sys_rst_i at 0.
- R5: After a time-out, wdog_no stays 0 until a kick transition clears it. Neither sys_rst_i nor a change of supply_low_i releases it.
- R6: While supply_low_i is 1, wdog_no is 0 in the same cycle, with no clock edge needed.
- R7: When supply_low_i returns to 0 with no pending time-out, wdog_no returns to 1 in the same cycle. The timer keeps counting through undervoltage.
- R8: kick_i held constant at 1, or held constant at 0, still leads to a time-out after one period.
- R9: If a kick edge and the final tick fall on the same clock edge, the kick wins. No expiry pulse occurs, wdog_no stays 1, and a new period begins.
- R10: A kick pulse one clock wide produces two edges, and each one clears the timer.
- R11: expire_o is a single-cycle pulse, once per time-out. It does not repeat while wdog_no stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block |
| kick_i | input | 1 | Service input; any level change is a kick (asynchronous) |
| sys_rst_i | input | 1 | Supervisor reset-asserted flag; holds the timer cleared |
| supply_low_i | input | 1 | Supply below reset threshold flag (synchronous to clk_i) |
| wdog_no | output | 1 | Active-low watchdog output |
| expire_o | output | 1 | One-cycle time-out strobe |

## Verification
Suppose the prescaler or tick counter is off by one, or fails to clear. The falling edge of wdog_no would then move away from its exact edge after release or after a kick, so the bench checks the output one cycle before and one cycle at the expected expiry. A sticky time-out flag that clears wrongly shows up within a single cycle: wdog_no rises without a kick, for example after undervoltage or a supervisor reset. A lost kick edge or a wrong priority shows up one full period later, as an early or missing fall of wdog_no.

// File: rtl/kick_wdt_pkg.sv
package kick_wdt_pkg;
  typedef struct packed {
    logic expired;
    logic fire;
  } wdt_state_t;

  localparam int unsigned DEF_SYNC_STAGES   = 2;
  localparam int unsigned DEF_PRESCALE      = 32768;
  localparam int unsigned DEF_TIMEOUT_TICKS = 1600;
endpackage

// File: rtl/kick_wdt_edge.sv
module kick_wdt_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);
  logic kick_s, kick_q;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= 1'b0;
        else         sr_q <= kick_i;
      end
      assign kick_s = sr_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[SYNC_STAGES-2:0], kick_i};
      end
      assign kick_s = sr_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) kick_q <= 1'b0;
    else         kick_q <= kick_s;
  end

  // both polarities service the timer
  assign edge_o = kick_s ^ kick_q;
endmodule

// File: rtl/kick_wdt_prescale.sv
module kick_wdt_prescale #(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] div_q;

      assign tick_o = (div_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      div_q <= '0;
        else if (clear_i) div_q <= '0;
        else if (tick_o)  div_q <= '0;
        else              div_q <= div_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/kick_wdt_count.sv
module kick_wdt_count
  import kick_wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       kick_i,
  input  logic       tick_i,
  output wdt_state_t state_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic [CW-1:0] cnt_q;
  wdt_state_t    st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= '0;
    end else begin
      st_q.fire <= 1'b0;
      if (kick_i) st_q.expired <= 1'b0;
      // clear beats the final tick
      if (kick_i || hold_i) begin
        cnt_q <= '0;
      end else if (tick_i && !st_q.expired) begin
        if (cnt_q == LAST) begin
          cnt_q        <= '0;
          st_q.expired <= 1'b1;
          st_q.fire    <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/kick_wdt.sv
module kick_wdt
  import kick_wdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES,
  parameter int unsigned PRESCALE      = DEF_PRESCALE,
  parameter int unsigned TIMEOUT_TICKS = DEF_TIMEOUT_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic sys_rst_i,
  input  logic supply_low_i,
  output logic wdog_no,
  output logic expire_o
);
  logic       kick_edge;
  logic       tick;
  wdt_state_t state;

  kick_wdt_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge)
  );

  kick_wdt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (kick_edge | sys_rst_i),
    .tick_o  (tick)
  );

  kick_wdt_count #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hold_i  (sys_rst_i),
    .kick_i  (kick_edge),
    .tick_i  (tick),
    .state_o (state)
  );

  // undervoltage acts without a clock edge
  assign wdog_no  = ~(state.expired | supply_low_i);
  assign expire_o = state.fire;
endmodule

// File: rtl/kick_wdt_checker.sv
module kick_wdt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_i,
  input logic supply_low_i,
  input logic kick_edge,
  input logic wdog_no,
  input logic expire_o
);
  AST_SUPPLY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> !wdog_no); // R6
  AST_PULSE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> !wdog_no); // R2
  AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o); // R11
  AST_RESET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> !expire_o); // R4
  AST_STAY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdog_no && !supply_low_i && !kick_edge) |=> !wdog_no); // R5
  AST_KICK_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> (wdog_no || supply_low_i)); // R3
  AST_KICK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> !expire_o); // R9
endmodule

bind kick_wdt kick_wdt_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sys_rst_i    (sys_rst_i),
  .supply_low_i (supply_low_i),
  .kick_edge    (kick_edge),
  .wdog_no      (wdog_no),
  .expire_o     (expire_o)
);

// File: tb/kick_wdt_bench.sv
module kick_wdt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;
  localparam int TO  = 5;
  localparam int PER = PRE * TO;  // edges from clear to expiry
  localparam int LAT = 3;         // sync stages + edge register

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic kick_i = 1'b0;
  logic sys_rst_i = 1'b1;
  logic supply_low_i = 1'b0;
  logic wdog_no, expire_o;
  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kick_wdt #(.SYNC_STAGES(2), .PRESCALE(PRE), .TIMEOUT_TICKS(TO)) u_kick_wdt (
    .clk_i(clk), .rst_ni(rst_ni), .kick_i(kick_i), .sys_rst_i(sys_rst_i),
    .supply_low_i(supply_low_i), .wdog_no(wdog_no), .expire_o(expire_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait n edges, expiry strobe must stay low throughout
  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (expire_o) seen++;
    end
    chk(req, seen, 0);
  endtask

  task automatic t_reset_state;
    step(2);
    rst_ni = 1'b1;
    step(3);
    chk("R1 wdog_no", int'(wdog_no), 1);
    chk("R1 expire_o", int'(expire_o), 0);
  endtask

  task automatic t_timeout;
    sys_rst_i = 1'b0;
    step(PER - 1);
    chk("R2 before expiry", int'(wdog_no), 1);
    step(1);
    chk("R2 at expiry", int'(wdog_no), 0);
    chk("R2 strobe", int'(expire_o), 1);
    step(1);
    chk("R11 strobe one cycle", int'(expire_o), 0);
    quiet(30, "R11 no repeat");
    chk("R5 still low", int'(wdog_no), 0);
  endtask

  task automatic t_edges_and_levels;
    kick_i = 1'b1;  // rising
    step(LAT - 1);
    chk("R3 rise latency", int'(wdog_no), 0);
    step(1);
    chk("R3 rise clears", int'(wdog_no), 1);
    step(PER - 1);
    chk("R8 held high pre", int'(wdog_no), 1);
    step(1);
    chk("R8 held high expires", int'(wdog_no), 0);
    kick_i = 1'b0;  // falling
    step(LAT);
    chk("R3 fall clears", int'(wdog_no), 1);
    step(PER - 1);
    chk("R8 held low pre", int'(wdog_no), 1);
    step(1);
    chk("R8 held low expires", int'(wdog_no), 0);
  endtask

  task automatic t_reset_hold;
    kick_i = 1'b1;
    step(LAT);
    step(10);
    sys_rst_i = 1'b1;
    for (int i = 0; i < 50; i++) begin
      step(1);
      if (!wdog_no) begin
        chk("R4 held in reset", int'(wdog_no), 1);
        break;
      end
    end
    sys_rst_i = 1'b0;
    step(PER - 1);
    chk("R4 restart pre", int'(wdog_no), 1);
    step(1);
    chk("R4 restart expiry", int'(wdog_no), 0);
    sys_rst_i = 1'b1;
    step(3);
    chk("R5 reset does not release", int'(wdog_no), 0);
    sys_rst_i = 1'b0;
  endtask

  task automatic t_supply;
    kick_i = 1'b0;
    step(LAT);
    chk("R3 recover", int'(wdog_no), 1);
    step(2);
    supply_low_i = 1'b1;
    #1;
    chk("R6 immediate low", int'(wdog_no), 0);
    step(5);
    chk("R6 held low", int'(wdog_no), 0);
    supply_low_i = 1'b0;
    #1;
    chk("R7 immediate high", int'(wdog_no), 1);
    step(PER - 7 - 1);
    chk("R7 timer kept counting pre", int'(wdog_no), 1);
    step(1);
    chk("R7 timer kept counting", int'(wdog_no), 0);
    supply_low_i = 1'b1;
    step(1);
    supply_low_i = 1'b0;
    #1;
    chk("R5 supply does not release", int'(wdog_no), 0);
  endtask

  task automatic t_priority;
    kick_i = 1'b1;
    step(LAT);
    chk("R3 recover", int'(wdog_no), 1);
    step(PER - LAT);
    kick_i = 1'b0;  // clearing edge lands on expiry edge
    quiet(LAT, "R9 no strobe");
    chk("R9 stays high", int'(wdog_no), 1);
    step(PER - 1);
    chk("R9 new period pre", int'(wdog_no), 1);
    step(1);
    chk("R9 new period expiry", int'(wdog_no), 0);
  endtask

  task automatic t_short_pulse;
    kick_i = 1'b1;
    step(LAT);
    step(10);
    kick_i = 1'b0;
    step(1);
    kick_i = 1'b1;
    step(LAT);
    step(PER - 1);
    chk("R10 second edge seen", int'(wdog_no), 1);
    step(1);
    chk("R10 expiry after second edge", int'(wdog_no), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_timeout();
    t_edges_and_levels();
    t_reset_hold();
    t_supply();
    t_priority();
    t_short_pulse();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule